// File: doc/BRIEF.md
# Double-Precision Funnel Shift Unit

This unit shifts a destination word left or right by a run-time count. The vacated bit positions are filled from a second source word rather than with zeros or copies of the sign bit. A left shift takes its fill bits from the top of the source, and a right shift takes them from the bottom. The source is only read and never appears as a result. A caller can therefore feed the same source word to the next word of a multi-word shift. A caller can also pack bit fields by issuing several shifts in turn and feeding each new destination back in.

Each operation is presented with a one-cycle valid strobe. It carries a destination, a source, a direction, a count and an operand size of 16 or 32 bits. One cycle later the unit presents the registered result and the flags. The flags are carry, overflow, sign, zero and parity, each group with its own write enable, plus an invalid-count indication. The registered outputs hold their values until the next strobe.

Top module: `fs_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. All result and flag outputs change only in that cycle and otherwise hold their values.
- R2: With `dir_i`=0 (left) and count c, the result is the destination shifted left by c. Its c low bits are the c most significant source bits, in order.
- R3: With `dir_i`=1 (right) and count c, the result is the destination shifted right by c. Its c high bits are the c least significant source bits, in order.
- R4: For a performed shift, `cf_o` is the last destination bit shifted out and `cf_we_o` is 1. A performed shift is a nonzero count that is in range.
- R5: Only the low 5 bits of `count_i` are used. A masked count of 0 returns the destination unchanged, with every write enable and every flag output at 0.
- R6: With `size_i`=0 (16 bit) and a masked count of 16 or more, `invalid_o` is 1. The result equals the destination, and every write enable is 0.
- R7: For a performed shift, `szp_we_o` is 1. `sf_o` is the result's top bit and `zf_o` is 1 when the result is zero. `pf_o` is 1 when the result's low byte has an even number of ones.
- R8: For a masked count of 1, `of_we_o` is 1 and `of_o` is the result's top bit XOR the destination's original top bit. For any other count, `of_we_o` and `of_o` are 0.
- R9: With `size_i`=0, only bits 15..0 of the destination and source take part, and bits 31..16 of the result are 0. With `size_i`=1, all 32 bits take part.
- R10: Four successive 16-bit left shifts by 4 each take a new source word and feed back the previous result. After them, the destination holds the four sources' top nibbles, with the first source in the top nibble.
- R11: Start from any 16-bit destination and shift right by 7, 5 and 4 with three sources in turn. The result then holds the third source's low 4 bits in 15..12, the second's low 5 bits in 11..7 and the first's low 7 bits in 6..0.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| dir_i | input | 1 | 0 shifts left, 1 shifts right |
| size_i | input | 1 | 0 selects 16-bit operands, 1 selects 32-bit operands |
| count_i | input | 8 | Shift count; only the low 5 bits are used |
| dst_i | input | 32 | Destination word |
| src_i | input | 32 | Fill source word, read only |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 32 | New destination value |
| cf_o | output | 1 | Carry: last bit shifted out |
| cf_we_o | output | 1 | Carry write enable |
| of_o | output | 1 | Overflow for a count of 1 |
| of_we_o | output | 1 | Overflow write enable |
| sf_o | output | 1 | Sign of the result |
| zf_o | output | 1 | Result is zero |
| pf_o | output | 1 | Even parity of the result's low byte |
| szp_we_o | output | 1 | Sign, zero and parity write enable |
| invalid_o | output | 1 | Count out of range for the 16-bit size |

## Verification
On every cycle, the assertions check the following:
- the one-cycle latency of the output strobe and the holding of results between strobes;
- that all flags are silenced on a zero count;
- the invalid path for 16-bit counts of 16 or more;
- the agreement between the zero flag and the result;
- that the overflow write enable appears only after a count of 1;
- the cleared upper half of the result in 16-bit mode.

The actual bit movement can only be shown by comparing whole results against the bench's bit-serial model. That covers the direction of the shift, the order of the fill bits from the source, the carry and parity values, and the masking of wide counts. The same holds for the chained scenarios, which depend on feeding each result back: packing four nibbles and packing a three-field date.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned FS_W     = 32;
  localparam int unsigned FS_CNT_W = $clog2(FS_W);

  typedef enum logic {
    FS_LEFT  = 1'b0,
    FS_RIGHT = 1'b1
  } fs_dir_e;

  typedef struct packed {
    logic invalid;
    logic szp_we;
    logic pf;
    logic zf;
    logic sf;
    logic of_we;
    logic of;
    logic cf_we;
    logic cf;
  } fs_flags_t;
endpackage

// File: rtl/fs_funnel.sv
module fs_funnel #(
  parameter int unsigned N     = 32,
  parameter int unsigned CNT_W = 5
) (
  input  logic [N-1:0]     dst_i,
  input  logic [N-1:0]     src_i,
  input  fs_pkg::fs_dir_e  dir_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [N-1:0]     res_o,
  output logic             cf_o
);
  localparam int unsigned CAT_W = 2 * N + 1;

  logic [CAT_W-1:0] left_cat, right_cat;

  // guard bit on the exit side catches the carry
  always_comb begin
    left_cat  = {1'b0, dst_i, src_i} << cnt_i;
    right_cat = {src_i, dst_i, 1'b0} >> cnt_i;
    if (dir_i == fs_pkg::FS_LEFT) begin
      res_o = left_cat[2*N-1:N];
      cf_o  = left_cat[2*N];
    end else begin
      res_o = right_cat[N:1];
      cf_o  = right_cat[0];
    end
  end
endmodule

// File: rtl/fs_flag_gen.sv
module fs_flag_gen #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] res_i,
  input  logic         dst_msb_i,
  output logic         sf_o,
  output logic         zf_o,
  output logic         pf_o,
  output logic         of_o
);
  always_comb begin
    sf_o = res_i[N-1];
    zf_o = (res_i == '0);
    pf_o = ~(^res_i[7:0]);
    of_o = res_i[N-1] ^ dst_msb_i;
  end
endmodule

// File: rtl/fs_unit.sv
module fs_unit #(
  parameter int unsigned W     = fs_pkg::FS_W,
  parameter int unsigned CNT_W = $clog2(W),
  parameter int unsigned CIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             dir_i,
  input  logic             size_i,
  input  logic [CIN_W-1:0] count_i,
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  output logic             valid_o,
  output logic [W-1:0]     result_o,
  output logic             cf_o,
  output logic             cf_we_o,
  output logic             of_o,
  output logic             of_we_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             pf_o,
  output logic             szp_we_o
  ,output logic            invalid_o
);
  import fs_pkg::*;

  localparam int unsigned HALF   = W / 2;
  localparam int unsigned LANES  = 2;

  logic [CNT_W-1:0] cnt;
  fs_dir_e          dir;
  logic             zero_cnt, over_cnt;
  logic [W-1:0]     dst_sized;

  logic [W-1:0] lane_res [LANES];
  logic         lane_cf  [LANES];
  logic         lane_sf  [LANES];
  logic         lane_zf  [LANES];
  logic         lane_pf  [LANES];
  logic         lane_of  [LANES];

  logic [W-1:0] res_d, res_q;
  fs_flags_t    flg_d, flg_q;
  logic         valid_q;
  logic         sel;

  assign cnt = count_i[CNT_W-1:0];
  assign dir = fs_dir_e'(dir_i);

  // lane 0: full width, lane 1: half width
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned N = W >> g;
    logic [N-1:0] res_n;
    logic         cf_n;

    fs_funnel #(.N(N), .CNT_W(CNT_W)) u_funnel (
      .dst_i (dst_i[N-1:0]),
      .src_i (src_i[N-1:0]),
      .dir_i (dir),
      .cnt_i (cnt),
      .res_o (res_n),
      .cf_o  (cf_n)
    );

    fs_flag_gen #(.N(N)) u_flags (
      .res_i     (res_n),
      .dst_msb_i (dst_i[N-1]),
      .sf_o      (lane_sf[g]),
      .zf_o      (lane_zf[g]),
      .pf_o      (lane_pf[g]),
      .of_o      (lane_of[g])
    );

    if (N == W) begin : g_full
      assign lane_res[g] = res_n;
    end else begin : g_ext
      assign lane_res[g] = {{(W - N){1'b0}}, res_n};
    end
    assign lane_cf[g] = cf_n;
  end

  always_comb begin
    sel       = ~size_i;
    zero_cnt  = (cnt == '0);
    over_cnt  = ~size_i & (cnt >= CNT_W'(HALF));
    dst_sized = size_i ? dst_i : {{HALF{1'b0}}, dst_i[HALF-1:0]};

    res_d = dst_sized;
    flg_d = '0;
    if (over_cnt) begin
      flg_d.invalid = 1'b1;
    end else if (!zero_cnt) begin
      res_d        = lane_res[sel];
      flg_d.cf_we  = 1'b1;
      flg_d.cf     = lane_cf[sel];
      flg_d.szp_we = 1'b1;
      flg_d.sf     = lane_sf[sel];
      flg_d.zf     = lane_zf[sel];
      flg_d.pf     = lane_pf[sel];
      flg_d.of_we  = (cnt == CNT_W'(1));
      flg_d.of     = flg_d.of_we & lane_of[sel];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign result_o  = res_q;
  assign cf_o      = flg_q.cf;
  assign cf_we_o   = flg_q.cf_we;
  assign of_o      = flg_q.of;
  assign of_we_o   = flg_q.of_we;
  assign sf_o      = flg_q.sf;
  assign zf_o      = flg_q.zf;
  assign pf_o      = flg_q.pf;
  assign szp_we_o  = flg_q.szp_we;
  assign invalid_o = flg_q.invalid;
endmodule

// File: rtl/fs_unit_chk.sv
module fs_unit_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CIN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             dir_i,
  input logic             size_i,
  input logic [CIN_W-1:0] count_i,
  input logic [W-1:0]     dst_i,
  input logic [W-1:0]     src_i,
  input logic             valid_o,
  input logic [W-1:0]     result_o,
  input logic             cf_o,
  input logic             cf_we_o,
  input logic             of_o,
  input logic             of_we_o,
  input logic             sf_o,
  input logic             zf_o,
  input logic             pf_o,
  input logic             szp_we_o,
  input logic             invalid_o
);
  localparam int unsigned HALF = W / 2;

  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(cf_o) && $stable(szp_we_o)));

  assert_zero_cnt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && count_i[CNT_W-1:0] == '0) |=>
      (!cf_we_o && !of_we_o && !szp_we_o && !invalid_o));

  assert_invalid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !size_i && count_i[CNT_W-1]) |=>
      (invalid_o && !cf_we_o && !szp_we_o &&
       result_o == {{HALF{1'b0}}, $past(dst_i[HALF-1:0])}));

  assert_zf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && szp_we_o) |-> (zf_o == (result_o == '0)));

  assert_of_we_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && of_we_o) |-> ($past(count_i[CNT_W-1:0]) == CNT_W'(1)));

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !size_i) |=> (result_o[W-1:HALF] == '0));
endmodule

bind fs_unit fs_unit_chk #(.W(W), .CNT_W(CNT_W), .CIN_W(CIN_W)) u_chk (.*);

// File: tb/sim_fs_unit.sv
module sim_fs_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dir_i = 1'b0;
  logic        size_i = 1'b0;
  logic [7:0]  count_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        cf_o, cf_we_o, of_o, of_we_o, sf_o, zf_o, pf_o, szp_we_o, invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  fs_unit u0 (
    .clk_i, .rst_ni, .valid_i, .dir_i, .size_i, .count_i, .dst_i, .src_i,
    .valid_o, .result_o, .cf_o, .cf_we_o, .of_o, .of_we_o, .sf_o, .zf_o,
    .pf_o, .szp_we_o, .invalid_o
  );

  function automatic logic [8:0] dut_flags();
    return {invalid_o, szp_we_o, pf_o, zf_o, sf_o, of_we_o, of_o, cf_we_o, cf_o};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bit-serial reference: one position per step
  function automatic void model(input logic dir, input logic sz32, input logic [7:0] cnt8,
                                input logic [31:0] dst, input logic [31:0] src,
                                output logic [31:0] r, output logic [8:0] f);
    int n = sz32 ? 32 : 16;
    int c = int'(cnt8[4:0]);
    logic [31:0] mask = sz32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] d = dst & mask;
    logic [31:0] s = src & mask;
    logic cf = 1'b0;
    logic orig_msb = d[n-1];
    f = '0;
    if (c == 0) begin
      r = d;
      return;
    end
    if (!sz32 && c >= 16) begin
      r = d;
      f[8] = 1'b1;
      return;
    end
    for (int i = 0; i < c; i++) begin
      if (!dir) begin
        cf = d[n-1];
        d = ((d << 1) | {31'b0, s[n-1]}) & mask;
        s = (s << 1) & mask;
      end else begin
        cf = d[0];
        d = (d >> 1) | ({31'b0, s[0]} << (n - 1));
        s = s >> 1;
      end
    end
    r = d;
    f[0] = cf;
    f[1] = 1'b1;
    if (c == 1) begin
      f[3] = 1'b1;
      f[2] = d[n-1] ^ orig_msb;
    end
    f[4] = d[n-1];
    f[5] = (d == 0);
    f[6] = ~(^d[7:0]);
    f[7] = 1'b1;
  endfunction

  task automatic run(input logic dir, input logic sz32, input logic [7:0] cnt8,
                     input logic [31:0] dst, input logic [31:0] src, output logic [31:0] r_act);
    logic [31:0] r_exp;
    logic [8:0]  f_exp;
    string tag;
    model(dir, sz32, cnt8, dst, src, r_exp, f_exp);
    @(negedge clk_i);
    valid_i = 1'b1; dir_i = dir; size_i = sz32; count_i = cnt8; dst_i = dst; src_i = src;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (f_exp[8]) tag = "R6";
    else if (cnt8[4:0] == 0) tag = "R5";
    else if (dir) tag = "R3";
    else tag = "R2";
    if (!sz32) tag = {tag, "/R9"};
    chk({tag, " result"}, {32'b0, result_o}, {32'b0, r_exp});
    chk("R4/R7/R8 flags", {55'b0, dut_flags()}, {55'b0, f_exp});
    chk("R1 valid_o", {63'b0, valid_o}, 64'd1);
    r_act = result_o;
  endtask

  initial begin
    logic [31:0] r, r_hold;
    logic [8:0]  f_hold;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    // R12: outputs cleared in reset
    chk("R12 reset outputs", {31'b0, valid_o, result_o}, 64'd0);
    chk("R12 reset flags", {55'b0, dut_flags()}, 64'd0);
    rst_ni = 1'b1;

    // R2/R3 basic and boundary counts
    run(1'b0, 1'b1, 8'd4,  32'h1234_5678, 32'hABCD_EF01, r);
    run(1'b1, 1'b1, 8'd4,  32'h1234_5678, 32'hABCD_EF01, r);
    run(1'b0, 1'b1, 8'd31, 32'h8000_0001, 32'hFFFF_FFFE, r);
    run(1'b1, 1'b0, 8'd15, 32'h0000_8001, 32'h0000_7FFF, r);
    // R8: count 1 overflow
    run(1'b0, 1'b0, 8'd1,  32'h0000_4000, 32'h0000_0000, r);
    chk("R8 of_o", {63'b0, of_o}, 64'd1);
    // R5: masking and zero count
    run(1'b0, 1'b1, 8'h21, 32'hC000_0000, 32'h8000_0000, r);
    run(1'b1, 1'b1, 8'h40, 32'hDEAD_BEEF, 32'h1234_5678, r);
    chk("R5 zero count keeps dst", {32'b0, r}, {32'b0, 32'hDEAD_BEEF});
    // R6: out-of-range 16-bit count
    run(1'b0, 1'b0, 8'd16, 32'hFFFF_1234, 32'h5555_5555, r);
    chk("R6 invalid_o", {63'b0, invalid_o}, 64'd1);
    // R1: hold without strobe
    r_hold = result_o; f_hold = dut_flags();
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 hold result", {32'b0, result_o}, {32'b0, r_hold});
    chk("R1 hold flags", {55'b0, dut_flags()}, {55'b0, f_hold});
    chk("R1 valid_o low", {63'b0, valid_o}, 64'd0);

    // R10: nibble packing
    r = 32'h0;
    run(1'b0, 1'b0, 8'd4, r, 32'h0000_A123, r);
    run(1'b0, 1'b0, 8'd4, r, 32'h0000_B456, r);
    run(1'b0, 1'b0, 8'd4, r, 32'h0000_C789, r);
    run(1'b0, 1'b0, 8'd4, r, 32'h0000_DABC, r);
    chk("R10 nibble pack", {32'b0, r}, {32'b0, 32'h0000_ABCD});

    // R11: date packing (year 96, day 26, month 9)
    r = 32'h0000_FFFF;
    run(1'b1, 1'b0, 8'd7, r, 32'd96, r);
    run(1'b1, 1'b0, 8'd5, r, 32'd26, r);
    run(1'b1, 1'b0, 8'd4, r, 32'd9, r);
    chk("R11 date pack", {32'b0, r}, {32'b0, 32'h0000_9D60});

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c8;
      c8 = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 17);
      run(1'($urandom), 1'($urandom), c8, $urandom, $urandom, r);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule